// File: doc/BRIEF.md
# Stream Byte Buffer with Send-Permission Flag

This block sits between a serial byte receiver and a stream consumer. Bytes arrive on a simple write strobe and are held in a first-in first-out store of 2048 entries. The consumer drains them through a valid/ready port, with the oldest byte always visible on the data output.

The block also drives a send-permission flag towards the host. The flag is registered. It is high only when the buffer still has room for at least a full safety burst of 32 bytes and the command side is not busy. A host that sees the flag high may therefore push a whole burst without polling again. Because the flag can drop at any time, the write port never depends on it. A byte that is already travelling is still stored, as long as there is physical room.

Top module: `stream_fifo_dreq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the buffer is emptied. After that edge `rd_valid` is 0, `data_req` is 1 and `overflow` is 0.
- R2: Bytes leave on `rd_data` in exactly the order they were accepted, and up to 2048 bytes can be held at once.
- R3: After every clock edge with `rst_n` high, `data_req` equals ((2048 − occupancy after that edge) ≥ 32) AND NOT `cmd_busy` as sampled at that edge. With 2016 bytes held it is 1, and with 2017 bytes held it is 0.
- R4: A `cmd_busy` of 1 sampled at an edge forces `data_req` to 0 after that edge, whatever the free space.
- R5: A write strobe is accepted whenever the buffer is not full at the edge. This holds regardless of `data_req` and `cmd_busy`.
- R6: A write strobe seen while the buffer holds 2048 bytes is discarded and leaves the stored contents unchanged. It sets `overflow`, which then stays 1 until reset.
- R7: `rd_valid` is 0 whenever the buffer is empty. Asserting `rd_ready` while empty removes nothing and changes nothing.
- R8: A write and a read in the same cycle both take effect, so occupancy is unchanged. When the buffer is full at that edge, the read proceeds and the write is discarded as in R6.
- R9: While `rd_valid` is 1, `rd_data` shows the oldest stored byte without waiting for `rd_ready` (first-word fall-through). A byte becomes visible in the cycle after the edge that stored it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe from the serial receiver |
| wr_data | input | 8 | Byte to store |
| rd_valid | output | 1 | A stored byte is available |
| rd_ready | input | 1 | Consumer takes the byte shown on rd_data |
| rd_data | output | 8 | Oldest stored byte |
| cmd_busy | input | 1 | Command execution in progress |
| data_req | output | 1 | Host may send another burst |
| overflow | output | 1 | Sticky flag: a byte was discarded because the buffer was full |

## Verification
Several properties are checked on every cycle by the assertions:
- the flag never claims room that the occupancy does not leave;
- a busy command always pulls the flag down on the next cycle;
- the overflow flag never clears outside reset;
- occupancy stays within the depth;
- a full buffer with a write and no read stays full.

Other behaviour can only be shown by the bench's scenarios, which compare against a queue model:
- byte ordering across a full fill-and-drain;
- the exact 2016/2017 boundary of the flag;
- that discarded bytes never reappear;
- that writes go through while the flag is low.

// File: rtl/sfq_pkg.sv
// Package: shared types for the stream byte buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sfq_pkg;

    // Kind of occupancy change in one cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } sfq_op_e;

endpackage

// File: rtl/sfq_storage.sv
// Module: sfq_storage
// Byte array with one synchronous write port and one asynchronous read port.
// Assumes the controller never writes and reads the same slot in a way that
// needs bypassing: a slot is only read once it has been written on an earlier edge.
module sfq_storage #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Present the slot at the read pointer.
    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/sfq_ptr_ctrl.sv
// Module: sfq_ptr_ctrl
// Pointer, occupancy and overflow control for the byte buffer.
// Decides which writes and reads are accepted, exports the next occupancy
// for the flag generator, and keeps the sticky overflow flag.
// Assumes a synchronous active-low reset.
module sfq_ptr_ctrl
    import sfq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_ready,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] occ_next,
    output logic          rd_valid,
    output logic          overflow
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc;
    logic [CW-1:0] occ_q, occ_d;
    logic          ovf_q;
    logic          full_w, empty_w, drop_w;
    sfq_op_e       op;

    // Classify the buffer state and the accepted operations.
    always_comb begin
        full_w  = (occ_q == FULL_C);
        empty_w = (occ_q == '0);
        push    = wr_en && !full_w;
        pop     = rd_ready && !empty_w;
        drop_w  = wr_en && full_w;
        op      = sfq_op_e'({push, pop});
    end

    // Pointer increment: natural wrap for a power-of-two depth, compare otherwise.
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            always_comb begin
                wr_ptr_inc = wr_ptr_q + 1'b1;
                rd_ptr_inc = rd_ptr_q + 1'b1;
            end
        end else begin : g_mod
            always_comb begin
                wr_ptr_inc = (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
                rd_ptr_inc = (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    endgenerate

    // Next occupancy from the accepted operations.
    always_comb begin
        unique case (op)
            OP_PUSH: occ_d = occ_q + 1'b1;
            OP_POP:  occ_d = occ_q - 1'b1;
            default: occ_d = occ_q;
        endcase
    end

    // Pointer, occupancy and overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_inc;
            if (pop)  rd_ptr_q <= rd_ptr_inc;
            occ_q <= occ_d;
            if (drop_w) ovf_q <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        wr_ptr   = wr_ptr_q;
        rd_ptr   = rd_ptr_q;
        occ      = occ_q;
        occ_next = occ_d;
        rd_valid = !empty_w;
        overflow = ovf_q;
    end

    // R2: occupancy never exceeds the depth.
    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL_C);

    // R6: a write into a full buffer with no read leaves it full.
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full_w && wr_en && !rd_ready) |=> full_w);

    // R6: overflow is sticky outside reset.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R8: a simultaneous accepted write and read keep occupancy.
    a_r8_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(occ_q));

    // R7: a read request on an empty buffer leaves it empty unless a write came.
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_w && rd_ready && !wr_en) |=> empty_w);

endmodule

// File: rtl/sfq_req_gen.sv
// Module: sfq_req_gen
// Registered send-permission flag. It is high when the free space after the
// current edge covers the safety burst and the command side is idle.
// Assumes occ_next is the occupancy that the buffer holds after the same edge.
module sfq_req_gen #(
    parameter int DEPTH  = 2048,
    parameter int MARGIN = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] occ_next,
    input  logic          cmd_busy,
    output logic          data_req
);

    localparam logic [CW:0] DEPTH_C  = (CW + 1)'(DEPTH);
    localparam logic [CW:0] MARGIN_C = (CW + 1)'(MARGIN);

    logic [CW:0] free_n;
    logic        req_d, req_q;

    // Free space after this edge, and the flag it implies.
    always_comb begin
        free_n = DEPTH_C - {1'b0, occ_next};
        req_d  = (free_n >= MARGIN_C) && !cmd_busy;
    end

    // Flag register; reset raises it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b1;
        end else begin
            req_q <= req_d;
        end
    end

    assign data_req = req_q;

    // R3: the flag never promises room the buffer does not have.
    a_r3_margin: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> ((DEPTH_C - {1'b0, occ}) >= MARGIN_C));

    // R4: a busy command lowers the flag on the next cycle.
    a_r4_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !req_q);

endmodule

// File: rtl/stream_fifo_dreq.sv
// Module: stream_fifo_dreq (top)
// Byte buffer between a serial receiver and a stream consumer, with a
// registered flag that tells the host whether another safety burst fits.
// Assumes one clock domain and a synchronous active-low reset. Writes are
// never gated by the flag: only a truly full buffer discards a byte.
module stream_fifo_dreq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048,
    parameter int MARGIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmd_busy,
    output logic              data_req,
    output logic              overflow
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ, occ_next;

    sfq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_ready (rd_ready),
        .push     (push),
        .pop      (pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ),
        .occ_next (occ_next),
        .rd_valid (rd_valid),
        .overflow (overflow)
    );

    sfq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    sfq_req_gen #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .occ      (occ),
        .occ_next (occ_next),
        .cmd_busy (cmd_busy),
        .data_req (data_req)
    );

    // R1: reset leaves the block empty, permitted and without overflow.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (data_req && !rd_valid && !overflow));

    // R7: no consumer transfer is possible while nothing is stored.
    a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> rd_valid);

endmodule

// File: tb/stream_fifo_dreq_tb_top.sv
module stream_fifo_dreq_tb_top;

    localparam int DEPTH  = 2048;
    localparam int MARGIN = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_ready, cmd_busy;
    logic [7:0] wr_data;
    logic       rd_valid, data_req, overflow;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] mq[$];
    bit         m_ovf;
    bit         m_req;

    always #5 clk = ~clk;

    stream_fifo_dreq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .cmd_busy (cmd_busy),
        .data_req (data_req),
        .overflow (overflow)
    );

    function automatic bit exp_req(input int size, input bit busy);
        return ((DEPTH - size) >= MARGIN) && !busy;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare(input bit busy);
        chk("R7 rd_valid", 32'(rd_valid), 32'(mq.size() != 0));
        if (mq.size() != 0) chk("R9 rd_data", 32'(rd_data), 32'(mq[0]));
        chk(busy ? "R4 data_req" : "R3 data_req", 32'(data_req), 32'(m_req));
        chk("R6 overflow", 32'(overflow), 32'(m_ovf));
    endtask

    // One cycle: drive at negedge, update the model, check at the next negedge.
    task automatic step(input logic we, input logic [7:0] d, input logic rr, input logic busy);
        bit is_full;
        bit do_pop;
        bit do_push;
        is_full = (mq.size() == DEPTH);
        do_pop  = rr && (mq.size() != 0);
        do_push = we && !is_full;
        wr_en = we; wr_data = d; rd_ready = rr; cmd_busy = busy;
        if (we && is_full) m_ovf = 1'b1;
        if (do_pop) void'(mq.pop_front());
        if (do_push) mq.push_back(d);
        m_req = exp_req(mq.size(), busy);
        @(posedge clk);
        @(negedge clk);
        compare(busy);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 0; rd_ready = 0; cmd_busy = 0; wr_data = '0;
        @(posedge clk);
        @(negedge clk);
        mq.delete(); m_ovf = 0; m_req = 1;
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 data_req", 32'(data_req), 32'd1);
        chk("R1 overflow", 32'(overflow), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 0; rd_ready = 0; cmd_busy = 0; wr_data = '0;
        @(negedge clk);
        do_reset();

        // R5: writes are accepted while busy holds the flag low.
        for (int i = 0; i < 5; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, 1'b1);
        chk("R4 flag low while busy", 32'(data_req), 32'd0);
        chk("R5 byte stored despite low flag", 32'(rd_data), 32'h10);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R3 flag back after busy", 32'(data_req), 32'd1);

        // R8: simultaneous write and read.
        step(1'b1, 8'hA5, 1'b1, 1'b0);
        chk("R8 head advanced", 32'(rd_data), 32'h11);
        while (mq.size() != 0) step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 empty after drain", 32'(rd_valid), 32'd0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 read on empty ignored", 32'(rd_valid), 32'd0);

        // R3 boundary at 2016 and 2017 held bytes.
        while (mq.size() < DEPTH - MARGIN) step(1'b1, 8'($urandom), 1'b0, 1'b0);
        chk("R3 flag high at 2016", 32'(data_req), 32'd1);
        step(1'b1, 8'h5A, 1'b0, 1'b0);
        chk("R3 flag low at 2017", 32'(data_req), 32'd0);

        // R2, R6: fill to full, overflow, then full write with read.
        while (mq.size() < DEPTH) step(1'b1, 8'($urandom), 1'b0, 1'b0);
        chk("R2 still valid at 2048", 32'(rd_valid), 32'd1);
        chk("R6 no overflow before drop", 32'(overflow), 32'd0);
        step(1'b1, 8'hEE, 1'b0, 1'b0);
        chk("R6 overflow set", 32'(overflow), 32'd1);
        step(1'b1, 8'hDD, 1'b1, 1'b0);
        chk("R8 write dropped when full", 32'(mq.size()), 32'(DEPTH - 1));
        while (mq.size() != 0) step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 overflow sticky", 32'(overflow), 32'd1);

        // R1: reset mid-run clears everything.
        step(1'b1, 8'h77, 1'b0, 1'b1);
        do_reset();

        // Random phases with varying bias.
        for (int ph = 0; ph < 8; ph++) begin
            int wp;
            int rp;
            wp = (ph % 2 == 0) ? 85 : 35;
            rp = (ph % 2 == 0) ? 30 : 80;
            for (int i = 0; i < 3000; i++) begin
                step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < rp,
                     ($urandom % 100) < 15);
            end
        end
        finish_run();
    end

endmodule